// File: doc/BRIEF.md
# Quad Texture Status Generator

This block tracks the thread masks of one pixel quad from the moment it is launched. Each time a texture fetch is issued for the quad, it forms the status word that travels with the request into the texture pipe. That word has a four-bit per-pixel active mask, which lets the cache and the filter skip idle pixels. It also has a one-bit divergence flag, which tells the level-of-detail logic whether quad derivatives can be trusted.

Two masks are held. The current thread mask is loaded at launch from the promoted raster mask and can later be rewritten by the sequencer. The killed mask is loaded at launch with the pixels that have no covered sample, and it gains bits as kill events arrive. Fetches flagged as non-dependent, meaning that no later derivative depends on them, also drop killed pixels. Dependent fetches ignore the killed mask. The divergence flag depends on the shader type and on a per-instruction override. A combinational quad-off output reports when no live pixel remains.

Top module: `qts_quad_status`

## Requirements
- R1: A launch loads the current thread mask with the promoted raster mask and the killed mask with the bitwise inverse of the original raster mask. It also latches the pixel-shader flag.
- R2: For a fetch with the non-dependent flag set, the active mask is (NOT killed) AND predicate AND current mask, with bit i belonging to pixel i.
- R3: For a fetch with the non-dependent flag clear, the active mask is predicate AND current mask, and the killed mask has no effect on it.
- R4: The divergence flag is 0 when the override flag is set. Otherwise it is 1 for a quad launched as a non-pixel thread. Otherwise it is 0 only when the current mask is 4'hF, and 1 in every other case.
- R5: The override flag changes only the divergence flag. It never adds pixels to the active mask.
- R6: A kill event sets the killed-mask bits named in its lane mask, and those bits stay set until the next launch. A launch in the same cycle as a kill event or a mask write takes precedence over both.
- R7: A mask write replaces the current thread mask from the next cycle onward.
- R8: The status valid pulse follows each fetch strobe by one cycle. The active mask and divergence flag change only after a fetch and hold otherwise. A fetch sees the masks as they were before any update made in the same cycle.
- R9: Quad-off is high exactly when (current mask AND NOT killed mask) is zero.
- R10: After reset the masks are zero, the status outputs are zero and quad-off is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| launch_vld | input | 1 | Quad launch strobe |
| launch_orig | input | 4 | Original raster mask, one bit per pixel |
| launch_prom | input | 4 | Promoted raster mask |
| launch_pix | input | 1 | Launched threads are pixel threads |
| kill_vld | input | 1 | Kill event strobe |
| kill_lanes | input | 4 | Pixels killed by the event |
| ctm_wr_vld | input | 1 | Current-mask write strobe |
| ctm_wr_data | input | 4 | New current thread mask |
| fetch_vld | input | 1 | Texture fetch request strobe |
| fetch_pred | input | 4 | Instruction predicate mask |
| fetch_nodep | input | 1 | Fetch is non-dependent |
| fetch_ndv | input | 1 | Force non-divergent |
| stat_vld | output | 1 | Status valid, one cycle after the fetch |
| stat_active | output | 4 | Per-pixel active mask |
| stat_div | output | 1 | Quad divergence flag |
| quad_off | output | 1 | No live pixel remains |

## Verification
A table of launches pairs full, partial and empty raster coverage with kill sets, predicates, both fetch kinds, both shader types and both override settings. Comparing the same launch under a dependent fetch and under a non-dependent fetch shows whether the killed mask reaches only non-dependent fetches. Comparing the same launch with the override on and off shows that only the divergence flag moves. Directed sequences then check kill stickiness across several fetches, launch precedence over a kill in the same cycle, mask writes, holding of outputs between fetches, and that a fetch ignores a same-cycle mask write.

// File: rtl/qts_pkg.sv
package qts_pkg;
  localparam int unsigned QTS_LANES = 4;
  typedef logic [QTS_LANES-1:0] lane_mask_t;

  // Active pixels for one fetch
  function automatic lane_mask_t qts_active(input lane_mask_t ctm, input lane_mask_t ktm,
                                            input lane_mask_t pred, input logic nodep);
    lane_mask_t base;
    base = pred & ctm;
    return nodep ? (base & ~ktm) : base;
  endfunction

  // Divergence: override first, then shader type, then full-quad test
  function automatic logic qts_divergent(input lane_mask_t ctm, input logic pix, input logic ndv);
    if (ndv) return 1'b0;
    if (!pix) return 1'b1;
    return (ctm != {QTS_LANES{1'b1}});
  endfunction

  function automatic logic qts_dead(input lane_mask_t ctm, input lane_mask_t ktm);
    return ((ctm & ~ktm) == '0);
  endfunction
endpackage

// File: rtl/qts_mask_store.sv
module qts_mask_store
  import qts_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       launch_vld,
  input  lane_mask_t launch_orig,
  input  lane_mask_t launch_prom,
  input  logic       launch_pix,
  input  logic       kill_vld,
  input  lane_mask_t kill_lanes,
  input  logic       ctm_wr_vld,
  input  lane_mask_t ctm_wr_data,
  output lane_mask_t ctm_q,
  output lane_mask_t ktm_q,
  output logic       pix_q
);
  // Named events for the assertions
  logic       launch_evt;
  lane_mask_t kill_hit;
  logic       ctm_wr_evt;

  assign launch_evt = launch_vld;
  assign kill_hit   = kill_vld ? kill_lanes : '0;
  assign ctm_wr_evt = ctm_wr_vld && !launch_vld;

  for (genvar i = 0; i < QTS_LANES; i++) begin : g_lane
    logic ctm_b, ktm_b;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ctm_b <= 1'b0;
        ktm_b <= 1'b0;
      end else if (launch_evt) begin
        ctm_b <= launch_prom[i];
        ktm_b <= ~launch_orig[i];
      end else begin
        if (ctm_wr_evt) ctm_b <= ctm_wr_data[i];
        if (kill_hit[i]) ktm_b <= 1'b1;
      end
    end
    assign ctm_q[i] = ctm_b;
    assign ktm_q[i] = ktm_b;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pix_q <= 1'b0;
    else if (launch_evt) pix_q <= launch_pix;
  end

  p_launch_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    launch_vld |=> (ctm_q == $past(launch_prom)) && (ktm_q == ~$past(launch_orig)));

  p_kill_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !launch_vld |=> ((ktm_q & $past(ktm_q)) == $past(ktm_q)));

  p_kill_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (kill_vld && !launch_vld) |=> ((ktm_q & $past(kill_lanes)) == $past(kill_lanes)));

  p_ctm_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctm_wr_vld && !launch_vld) |=> (ctm_q == $past(ctm_wr_data)));
endmodule

// File: rtl/qts_status_calc.sv
module qts_status_calc
  import qts_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fetch_vld,
  input  lane_mask_t fetch_pred,
  input  logic       fetch_nodep,
  input  logic       fetch_ndv,
  input  lane_mask_t ctm,
  input  lane_mask_t ktm,
  input  logic       pix,
  output logic       stat_vld,
  output lane_mask_t stat_active,
  output logic       stat_div
);
  lane_mask_t act_nxt;
  logic       div_nxt;

  always_comb begin
    act_nxt = qts_active(ctm, ktm, fetch_pred, fetch_nodep);
    div_nxt = qts_divergent(ctm, pix, fetch_ndv);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_vld    <= 1'b0;
      stat_active <= '0;
      stat_div    <= 1'b0;
    end else begin
      stat_vld <= fetch_vld;
      if (fetch_vld) begin
        stat_active <= act_nxt;
        stat_div    <= div_nxt;
      end
    end
  end

  p_vld_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_vld |=> stat_vld);

  p_vld_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_vld |=> !stat_vld);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_vld |=> ($stable(stat_active) && $stable(stat_div)));

  p_ndv_div_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_vld && fetch_ndv) |=> !stat_div);

  p_pred_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_vld |=> ((stat_active & ~$past(fetch_pred)) == '0));
endmodule

// File: rtl/qts_quad_status.sv
module qts_quad_status
  import qts_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       launch_vld,
  input  logic [3:0] launch_orig,
  input  logic [3:0] launch_prom,
  input  logic       launch_pix,
  input  logic       kill_vld,
  input  logic [3:0] kill_lanes,
  input  logic       ctm_wr_vld,
  input  logic [3:0] ctm_wr_data,
  input  logic       fetch_vld,
  input  logic [3:0] fetch_pred,
  input  logic       fetch_nodep,
  input  logic       fetch_ndv,
  output logic       stat_vld,
  output logic [3:0] stat_active,
  output logic       stat_div,
  output logic       quad_off
);
  lane_mask_t ctm_q, ktm_q;
  logic       pix_q;

  qts_mask_store u_store (
    .clk(clk), .rst_n(rst_n),
    .launch_vld(launch_vld), .launch_orig(launch_orig), .launch_prom(launch_prom),
    .launch_pix(launch_pix),
    .kill_vld(kill_vld), .kill_lanes(kill_lanes),
    .ctm_wr_vld(ctm_wr_vld), .ctm_wr_data(ctm_wr_data),
    .ctm_q(ctm_q), .ktm_q(ktm_q), .pix_q(pix_q)
  );

  qts_status_calc u_calc (
    .clk(clk), .rst_n(rst_n),
    .fetch_vld(fetch_vld), .fetch_pred(fetch_pred),
    .fetch_nodep(fetch_nodep), .fetch_ndv(fetch_ndv),
    .ctm(ctm_q), .ktm(ktm_q), .pix(pix_q),
    .stat_vld(stat_vld), .stat_active(stat_active), .stat_div(stat_div)
  );

  assign quad_off = qts_dead(ctm_q, ktm_q);

  // A dead quad yields an empty mask for a non-dependent fetch
  p_off_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_vld && fetch_nodep && quad_off) |=> (stat_active == '0));
endmodule

// File: tb/qts_quad_status_tb.sv
module qts_quad_status_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic launch_vld = 0, launch_pix = 0, kill_vld = 0, ctm_wr_vld = 0;
  logic fetch_vld = 0, fetch_nodep = 0, fetch_ndv = 0;
  logic [3:0] launch_orig = 0, launch_prom = 0, kill_lanes = 0, ctm_wr_data = 0, fetch_pred = 0;
  logic stat_vld, stat_div, quad_off;
  logic [3:0] stat_active;
  int total = 0, bad = 0, cyc = 0;

  always #5 clk = ~clk;

  qts_quad_status u_dut (.*);

  // {orig, prom, kill, pred, nodep, ndv, pix, exp_act, exp_div, exp_off}
  localparam int NV = 12;
  localparam logic [24:0] VEC [NV] = '{
    {4'hF,4'hF,4'h0,4'hF,1'b0,1'b0,1'b1,4'hF,1'b0,1'b0},
    {4'h5,4'hF,4'h0,4'hF,1'b1,1'b0,1'b1,4'h5,1'b0,1'b0},
    {4'h5,4'hF,4'h0,4'hF,1'b0,1'b0,1'b1,4'hF,1'b0,1'b0},
    {4'hF,4'hF,4'h3,4'hF,1'b1,1'b0,1'b1,4'hC,1'b0,1'b0},
    {4'hF,4'hF,4'h3,4'h6,1'b0,1'b0,1'b1,4'h6,1'b0,1'b0},
    {4'h1,4'h3,4'h0,4'hF,1'b0,1'b0,1'b1,4'h3,1'b1,1'b0},
    {4'h1,4'h3,4'h0,4'hF,1'b0,1'b1,1'b1,4'h3,1'b0,1'b0},
    {4'hF,4'hF,4'h0,4'hF,1'b0,1'b0,1'b0,4'hF,1'b1,1'b0},
    {4'hF,4'hF,4'h0,4'hF,1'b0,1'b1,1'b0,4'hF,1'b0,1'b0},
    {4'h0,4'h0,4'h0,4'hF,1'b0,1'b0,1'b1,4'h0,1'b1,1'b1},
    {4'hF,4'hF,4'hF,4'hF,1'b1,1'b0,1'b1,4'h0,1'b0,1'b1},
    {4'hF,4'hF,4'hF,4'hF,1'b0,1'b0,1'b1,4'hF,1'b0,1'b1}
  };

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic launch(input logic [3:0] o, input logic [3:0] p, input logic pix);
    launch_vld = 1; launch_orig = o; launch_prom = p; launch_pix = pix;
    step();
    launch_vld = 0;
  endtask

  task automatic kill(input logic [3:0] k);
    kill_vld = 1; kill_lanes = k;
    step();
    kill_vld = 0;
  endtask

  task automatic fetch(input logic [3:0] pr, input logic nd, input logic ndv);
    fetch_vld = 1; fetch_pred = pr; fetch_nodep = nd; fetch_ndv = ndv;
    step();
    fetch_vld = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step(); step();
    rst_n = 1;
    step();
    // R10: reset state
    chk("R10 vld", {3'b0, stat_vld}, 4'h0);
    chk("R10 active", stat_active, 4'h0);
    chk("R10 div", {3'b0, stat_div}, 4'h0);
    chk("R10 quad_off", {3'b0, quad_off}, 4'h1);

    // Table walk: R1 launch loading drives every expected value below
    for (int i = 0; i < NV; i++) begin
      logic [24:0] v;
      v = VEC[i];
      launch(v[24:21], v[20:17], v[6]);
      if (v[16:13] != 4'h0) kill(v[16:13]);
      chk("R9 quad_off", {3'b0, quad_off}, {3'b0, v[0]});
      fetch(v[12:9], v[8], v[7]);
      chk("R8 vld", {3'b0, stat_vld}, 4'h1);
      chk(v[8] ? "R2 active" : "R3 active", stat_active, v[5:2]);
      chk(v[7] ? "R5 div" : "R4 div", {3'b0, stat_div}, {3'b0, v[1]});
    end

    // R6: kills accumulate and persist until relaunch
    launch(4'hF, 4'hF, 1'b1);
    kill(4'h1);
    fetch(4'hF, 1'b1, 1'b0);
    chk("R6 first kill", stat_active, 4'hE);
    kill(4'h2);
    fetch(4'hF, 1'b1, 1'b0);
    chk("R6 sticky", stat_active, 4'hC);
    fetch(4'hF, 1'b1, 1'b0);
    chk("R6 still sticky", stat_active, 4'hC);
    launch(4'hF, 4'hF, 1'b1);
    fetch(4'hF, 1'b1, 1'b0);
    chk("R6 relaunch clears", stat_active, 4'hF);

    // R6: launch wins over same-cycle kill
    launch_vld = 1; launch_orig = 4'hF; launch_prom = 4'hF; launch_pix = 1;
    kill_vld = 1; kill_lanes = 4'hF;
    step();
    launch_vld = 0; kill_vld = 0;
    chk("R6 launch priority off", {3'b0, quad_off}, 4'h0);
    fetch(4'hF, 1'b1, 1'b0);
    chk("R6 launch priority", stat_active, 4'hF);

    // R7: mask write
    ctm_wr_vld = 1; ctm_wr_data = 4'h7;
    step();
    ctm_wr_vld = 0;
    fetch(4'hF, 1'b0, 1'b0);
    chk("R7 active", stat_active, 4'h7);
    chk("R7 div", {3'b0, stat_div}, 4'h1);

    // R8: hold between fetches, single-cycle valid
    step();
    chk("R8 vld drops", {3'b0, stat_vld}, 4'h0);
    chk("R8 hold", stat_active, 4'h7);

    // R8: fetch sees masks before a same-cycle write
    ctm_wr_vld = 1; ctm_wr_data = 4'h1;
    fetch(4'hF, 1'b0, 1'b0);
    ctm_wr_vld = 0;
    chk("R8 pre-update view", stat_active, 4'h7);
    fetch(4'hF, 1'b0, 1'b0);
    chk("R7 after write", stat_active, 4'h1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule